// File: doc/BRIEF.md
# Prescaled Down-Counting Interval Timer

This block is one 32-bit interval timer that counts down and is driven by software through a small synchronous register port. Software sets a start value, picks a clock divider and an operating mode, then enables counting. The live count can be read back at any moment. When a counting step finds the count already at zero, a sticky interrupt flag goes high. It stays high until software writes the clear register.

Two operating modes exist. In wrap mode the count rolls from zero to all-ones and keeps going. In reload mode it returns to the stored start value, so zero events repeat at a fixed interval. The divider lets the count step on every clock, on every 16th clock or on every 256th clock. Any write of the start value restarts counting from that value at once. Several copies can sit side by side to form a timer bank.

Top module: `ival_timer`

## Requirements
- R1: After synchronous reset, the start value, the count, the control register and the interrupt flag all read as zero.
- R2: While enabled with divider code 00, the count drops by one on every clock edge.
- R3: Control bits 3:2 choose the divider: 01 steps the count once every 16 clocks, 10 once every 256 clocks, and the code 11 behaves like 10. After a restart, the first step comes one full divider period later.
- R4: In wrap mode (control bit 6 = 0), a step that finds the count at zero sets the flag and leaves the count at 0xFFFFFFFF.
- R5: In reload mode (control bit 6 = 1), a step that finds the count at zero sets the flag and reloads the count from the start-value register.
- R6: A write to offset 0x0 places the written value in the count on the next cycle. It also resets the divider phase, and no step happens in that cycle.
- R7: Reads are combinational. Offset 0x0 returns the start value, 0x4 the live count, and 0x8 the control register with enable in bit 7, mode in bit 6, divider in bits 3:2 and zeros elsewhere. Reading does not change counting. An access whose address bits 1:0 are not 00 is ignored.
- R8: The interrupt flag stays high until software writes any value to offset 0xC.
- R9: If a zero event and a clear write fall in the same cycle, the flag stays set.
- R10: While control bit 7 (enable) is 0, the count and the divider phase hold, and no interrupt is raised even with a count of zero.
- R11: A control write that changes enable from 0 to 1 resets the divider phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 4 | Byte address of the register access |
| wr_en | input | 1 | Write strobe for the current cycle |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Sticky interrupt flag |

## Verification
The assertions check the single-step rules on every cycle: a step decrements the count, a zero step wraps or reloads it, a start-value write lands in the count, a disabled timer holds its count, the flag is sticky, and a clear loses to a simultaneous zero event. Some behaviours span a whole interval, and only the bench scenarios can show them. These are the 16- and 256-clock divider periods, the reserved divider code, the phase reset on restart and on enable, address decoding and read-back, and the full repeat cycle of reload mode.

// File: rtl/ival_pkg.sv
package ival_pkg;

    localparam int CNT_W        = 32;
    localparam int ADDR_W       = 4;
    localparam int DIV_MID_LOG2 = 4;
    localparam int DIV_HI_LOG2  = 8;

    localparam int CTRL_EN_BIT   = 7;
    localparam int CTRL_MODE_BIT = 6;
    localparam int CTRL_PS_LSB   = 2;

    typedef enum logic [1:0] {
        PS_DIV1   = 2'b00,
        PS_DIV16  = 2'b01,
        PS_DIV256 = 2'b10,
        PS_RSVD   = 2'b11
    } ps_sel_e;

    typedef enum logic [1:0] {
        SEL_LOAD  = 2'd0,
        SEL_VALUE = 2'd1,
        SEL_CTRL  = 2'd2,
        SEL_CLEAR = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic    en;
        logic    periodic;
        ps_sel_e ps;
    } ctrl_t;

    function automatic ctrl_t ctrl_unpack(input logic [CNT_W-1:0] w);
        ctrl_t c;
        c.en       = w[CTRL_EN_BIT];
        c.periodic = w[CTRL_MODE_BIT];
        c.ps       = ps_sel_e'(w[CTRL_PS_LSB +: 2]);
        return c;
    endfunction

    function automatic logic [CNT_W-1:0] ctrl_pack(input ctrl_t c);
        logic [CNT_W-1:0] w;
        w                     = '0;
        w[CTRL_EN_BIT]        = c.en;
        w[CTRL_MODE_BIT]      = c.periodic;
        w[CTRL_PS_LSB +: 2]   = c.ps;
        return w;
    endfunction

endpackage

// File: rtl/ival_regs.sv
module ival_regs
    import ival_pkg::*;
#(
    parameter int W  = CNT_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    input  logic [W-1:0]  wdata,
    input  logic [W-1:0]  cnt_q,
    output logic [W-1:0]  load_q,
    output ctrl_t         ctrl_q,
    output logic          load_wr,
    output logic          clr_wr,
    output logic          en_rise,
    output logic [W-1:0]  rdata
);

    reg_sel_e sel;
    logic     aligned;
    logic     hit;
    logic     ctrl_wr;

    assign sel     = reg_sel_e'(addr[3:2]);
    assign aligned = (addr[1:0] == 2'b00);
    assign hit     = wr_en && aligned;
    assign load_wr = hit && (sel == SEL_LOAD);
    assign ctrl_wr = hit && (sel == SEL_CTRL);
    assign clr_wr  = hit && (sel == SEL_CLEAR);
    assign en_rise = ctrl_wr && wdata[CTRL_EN_BIT] && !ctrl_q.en;

    always_ff @(posedge clk) begin
        if (rst) begin
            load_q <= '0;
            ctrl_q <= '0;
        end else begin
            if (load_wr) load_q <= wdata;
            if (ctrl_wr) ctrl_q <= ctrl_unpack(wdata);
        end
    end

    always_comb begin
        rdata = '0;
        if (aligned) begin
            case (sel)
                SEL_LOAD:  rdata = load_q;
                SEL_VALUE: rdata = cnt_q;
                SEL_CTRL:  rdata = ctrl_pack(ctrl_q);
                default:   rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/ival_prescaler.sv
module ival_prescaler
    import ival_pkg::*;
#(
    parameter int MID_LOG2 = DIV_MID_LOG2,
    parameter int HI_LOG2  = DIV_HI_LOG2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    en,
    input  logic    restart,
    input  ps_sel_e ps,
    output logic    tick
);

    localparam int PW = HI_LOG2;
    localparam logic [PW-1:0] LIM_MID = PW'((1 << MID_LOG2) - 1);
    localparam logic [PW-1:0] LIM_HI  = '1;

    logic [PW-1:0] pcnt;
    logic [PW-1:0] limit;

    always_comb begin
        case (ps)
            PS_DIV1:  limit = '0;
            PS_DIV16: limit = LIM_MID;
            default:  limit = LIM_HI;
        endcase
    end

    // >= keeps a phase left over from a longer divider from overshooting
    assign tick = en && !restart && (pcnt >= limit);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            pcnt <= '0;
        end else if (en) begin
            pcnt <= tick ? '0 : pcnt + 1'b1;
        end
    end

endmodule

// File: rtl/ival_counter.sv
module ival_counter
    import ival_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         periodic,
    input  logic         load_wr,
    input  logic [W-1:0] wr_val,
    input  logic [W-1:0] reload_val,
    input  logic         clr_wr,
    output logic [W-1:0] cnt_q,
    output logic         irq
);

    logic zero_hit;
    logic [W-1:0] step_val;

    assign zero_hit = tick && (cnt_q == '0);
    assign step_val = (zero_hit && periodic) ? reload_val : cnt_q - 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            irq   <= 1'b0;
        end else begin
            if (load_wr)   cnt_q <= wr_val;
            else if (tick) cnt_q <= step_val;

            if (zero_hit)    irq <= 1'b1;
            else if (clr_wr) irq <= 1'b0;
        end
    end

endmodule

// File: rtl/ival_timer.sv
module ival_timer
    import ival_pkg::*;
#(
    parameter int W        = CNT_W,
    parameter int AW       = ADDR_W,
    parameter int MID_LOG2 = DIV_MID_LOG2,
    parameter int HI_LOG2  = DIV_HI_LOG2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata,
    output logic          irq
);

    logic [W-1:0] cnt_q;
    logic [W-1:0] load_q;
    ctrl_t        ctrl_q;
    logic         load_wr;
    logic         clr_wr;
    logic         en_rise;
    logic         tick;
    logic         en_q;
    logic         periodic_q;

    assign en_q       = ctrl_q.en;
    assign periodic_q = ctrl_q.periodic;

    ival_regs #(.W(W), .AW(AW)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .addr    (addr),
        .wr_en   (wr_en),
        .wdata   (wdata),
        .cnt_q   (cnt_q),
        .load_q  (load_q),
        .ctrl_q  (ctrl_q),
        .load_wr (load_wr),
        .clr_wr  (clr_wr),
        .en_rise (en_rise),
        .rdata   (rdata)
    );

    ival_prescaler #(.MID_LOG2(MID_LOG2), .HI_LOG2(HI_LOG2)) u_ps (
        .clk     (clk),
        .rst     (rst),
        .en      (en_q),
        .restart (load_wr || en_rise),
        .ps      (ctrl_q.ps),
        .tick    (tick)
    );

    ival_counter #(.W(W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .periodic   (periodic_q),
        .load_wr    (load_wr),
        .wr_val     (wdata),
        .reload_val (load_q),
        .clr_wr     (clr_wr),
        .cnt_q      (cnt_q),
        .irq        (irq)
    );

endmodule

// File: rtl/ival_timer_chk.sv
module ival_timer_chk #(
    parameter int W  = 32,
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] addr,
    input logic          wr_en,
    input logic [W-1:0]  wdata,
    input logic          irq,
    input logic [W-1:0]  cnt_q,
    input logic [W-1:0]  load_q,
    input logic          tick,
    input logic          en_q,
    input logic          periodic_q
);

    logic ld_w, clr_w;
    assign ld_w  = wr_en && (addr == 4'h0);
    assign clr_w = wr_en && (addr == 4'hC);

    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> (cnt_q == '0 && !irq && load_q == '0));

    // R2
    step_dec_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && cnt_q != '0 && !ld_w) |=> cnt_q == $past(cnt_q) - 1'b1);

    // R4
    wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && cnt_q == '0 && !periodic_q) |=> cnt_q == '1);

    // R5
    reload_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && cnt_q == '0 && periodic_q) |=> cnt_q == $past(load_q));

    // R6
    load_restart_chk: assert property (@(posedge clk) disable iff (rst)
        ld_w |=> cnt_q == $past(wdata));

    // R8
    irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && !clr_w) |=> irq);

    // R9
    clear_collision_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_w && tick && cnt_q == '0) |=> irq);

    // R10
    disabled_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!en_q && !ld_w) |=> $stable(cnt_q));

    // R10
    irq_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(tick && en_q && cnt_q == '0));

endmodule

bind ival_timer ival_timer_chk #(.W(W), .AW(AW)) u_chk (.*);

// File: tb/sim_ival_timer.sv
`timescale 1ns/100ps
module sim_ival_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    always #5 clk = ~clk;

    ival_timer u0 (.clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en),
                   .wdata(wdata), .rdata(rdata), .irq(irq));

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    event  item_ev;
    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 0;

    // monitor: pops expected items and compares with the live outputs
    initial begin
        forever begin
            @(item_ev);
            #0.5;
            while (q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it  = q.pop_front();
                act = it.is_irq ? {31'd0, irq} : rdata;
                n_chk++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic [3:0] a, input logic [31:0] e, input string tag);
        item_t it;
        addr = a;
        it.is_irq = 0; it.exp = e; it.tag = tag;
        q.push_back(it);
        -> item_ev;
        #1;
    endtask

    task automatic chk_irq(input bit e, input string tag);
        item_t it;
        it.is_irq = 1; it.exp = {31'd0, e}; it.tag = tag;
        q.push_back(it);
        -> item_ev;
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);
        // R1 reset state
        chk(4'h0, 32'd0, "R1 load");
        chk(4'h4, 32'd0, "R1 value");
        chk(4'h8, 32'd0, "R1 ctrl");
        idle(1);
        chk_irq(0, "R1 irq");

        // R6 load while disabled, R10 hold
        wr(4'h0, 32'd10);
        chk(4'h4, 32'd10, "R6 load value");
        idle(5);
        chk(4'h4, 32'd10, "R10 disabled hold");
        // R7 misaligned write ignored
        wr(4'h1, 32'd99);
        chk(4'h0, 32'd10, "R7 misaligned ignored");

        // R2 free-running /1
        wr(4'h8, 32'h80);
        chk(4'h4, 32'd10, "R11 no step on enable");
        idle(4);
        chk(4'h4, 32'd6, "R2 decrement");
        chk(4'h8, 32'h80, "R7 ctrl readback");
        idle(6);
        chk(4'h4, 32'd0, "R4 at zero");
        chk_irq(0, "R4 no irq yet");
        idle(1);
        chk(4'h4, 32'hFFFFFFFF, "R4 wrap");
        chk_irq(1, "R4 irq set");
        idle(3);
        chk(4'h4, 32'hFFFFFFFC, "R4 continue");
        chk_irq(1, "R8 sticky");
        wr(4'hC, 32'd0);
        chk_irq(0, "R8 clear");

        // R5 periodic
        wr(4'h8, 32'hC0);
        wr(4'h0, 32'd3);
        idle(3);
        chk(4'h4, 32'd0, "R5 at zero");
        chk_irq(0, "R5 before zero step");
        idle(1);
        chk(4'h4, 32'd3, "R5 reload");
        chk_irq(1, "R5 irq");
        wr(4'hC, 32'd0);
        chk_irq(0, "R8 clear periodic");
        idle(3);
        chk(4'h4, 32'd3, "R5 second reload");
        chk_irq(1, "R5 repeat irq");
        wr(4'hC, 32'd0);
        chk_irq(0, "R8 clear again");
        idle(2);
        chk(4'h4, 32'd0, "R5 zero again");
        wr(4'hC, 32'd0);
        chk_irq(1, "R9 zero beats clear");
        chk(4'h4, 32'd3, "R9 reload in collision");

        // R3 divide by 16
        wr(4'h8, 32'h84);
        wr(4'h0, 32'd5);
        idle(15);
        chk(4'h4, 32'd5, "R3 /16 before period");
        idle(1);
        chk(4'h4, 32'd4, "R3 /16 first step");
        idle(16);
        chk(4'h4, 32'd3, "R3 /16 second step");

        // R3 divide by 256
        wr(4'h8, 32'h88);
        wr(4'h0, 32'd2);
        idle(255);
        chk(4'h4, 32'd2, "R3 /256 before period");
        idle(1);
        chk(4'h4, 32'd1, "R3 /256 step");

        // R3 reserved code behaves as /256
        wr(4'h8, 32'h8C);
        wr(4'h0, 32'd7);
        chk(4'h8, 32'h8C, "R7 ctrl reserved readback");
        idle(255);
        chk(4'h4, 32'd7, "R3 rsvd before period");
        idle(1);
        chk(4'h4, 32'd6, "R3 rsvd step");

        // R6 restart mid-count
        wr(4'h8, 32'h80);
        wr(4'h0, 32'd100);
        idle(10);
        chk(4'h4, 32'd90, "R2 running");
        wr(4'h0, 32'd50);
        chk(4'h4, 32'd50, "R6 restart value");
        chk(4'h0, 32'd50, "R7 load readback");
        idle(2);
        chk(4'h4, 32'd48, "R6 count after restart");

        // R10 disable
        wr(4'h8, 32'h00);
        chk(4'h4, 32'd47, "R10 last step at disable edge");
        idle(20);
        chk(4'h4, 32'd47, "R10 hold while disabled");
        chk(4'h8, 32'h00, "R7 ctrl disabled");
        wr(4'hC, 32'd0);
        wr(4'h0, 32'd0);
        idle(5);
        chk_irq(0, "R10 no irq at zero while disabled");
        chk(4'h4, 32'd0, "R10 zero held");

        // R11 enable resets divider phase
        wr(4'h8, 32'h84);
        wr(4'h0, 32'd20);
        idle(7);
        wr(4'h8, 32'h04);
        idle(10);
        chk(4'h4, 32'd20, "R10 hold with /16");
        wr(4'h8, 32'h84);
        idle(15);
        chk(4'h4, 32'd20, "R11 phase reset on enable");
        idle(1);
        chk(4'h4, 32'd19, "R11 first step after enable");

        idle(2);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule